// File: doc/BRIEF.md
# Six-Stage Pipeline Redirect and Squash Controller

This block sequences instructions through an in-order pipeline of six stages, in this order: instruction fetch (FI), decode (DI), operand address calculation (CO), operand fetch (FO), execute (EI) and result write (WO). Each stage register keeps a valid bit, the instruction's address as its tag, a two-bit branch kind and a branch target. When nothing redirects the flow, a new instruction is fetched on every cycle and every occupied stage moves one place forward per cycle. Instructions that need only some phases still pass through every stage. In the stages they do not use they act as no-ops.

Two kinds of branch change the flow, and each is acted on at a different depth. An unconditional jump is known once it sits in the address-calculation stage, so only the two stages behind it are discarded. A conditional branch is known only when it reaches execute. If the branch is taken, the four stages behind it are discarded. In both cases fetch restarts at the branch target on the following cycle. A running counter adds up how many real instructions were thrown away. The fetch environment returns the kind and target of the instruction at the current fetch address in the same cycle. The execute environment supplies the branch outcome.

Top module: `pfc_flush_ctrl`

## Requirements
- R1: While reset is held, every stage valid bit is 0, the fetch address equals RESET_PC and the squash counter is 0.
- R2: In a cycle with no redirect, the fetch address advances by exactly one at the clock edge, and the instruction at the old address enters FI as valid.
- R3: An instruction that is not discarded moves one stage per cycle and keeps its tag. It appears as the retire address with stage_valid[5] set five cycles after it enters FI.
- R4: A valid instruction in CO whose kind is 2'b01 (jump) clears stage_valid[1:0] in that same cycle. At the next edge the fetch address becomes the jump target.
- R5: A valid instruction in EI whose kind is 2'b10 (conditional), while exec_taken is 1, clears stage_valid[3:0] in that same cycle. At the next edge the fetch address becomes the branch target.
- R6: exec_taken has no effect unless EI holds a valid conditional branch. A conditional branch that is not taken causes no squash, no counter change and no break in fetch order.
- R7: The instruction being fetched in a redirect cycle is dropped, so FI is empty after that edge. The target instruction is fetched during the next cycle and enters FI one edge later.
- R8: On every redirect the counter grows by the number of valid instructions in the squashed stages. Empty slots are not counted, and the counter does not change in cycles without a redirect.
- R9: When a jump in CO and a taken conditional in EI occur in the same cycle, the conditional wins: its target is used and all four stages behind it are counted and squashed.
- R10: The redirecting branch itself and every older stage continue down the pipeline, and the branch retires normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_kind | input | 2 | Kind of the instruction at fetch_pc: 00 plain, 01 jump, 10 conditional, 11 plain |
| fetch_target | input | PC_W | Branch target of the instruction at fetch_pc |
| exec_taken | input | 1 | Outcome of the conditional branch currently in EI |
| fetch_pc | output | PC_W | Address being fetched this cycle |
| stage_valid | output | 6 | Per-stage valid after this cycle's squash, bit 0 = FI … bit 5 = WO |
| retire_pc | output | PC_W | Tag of the instruction in WO |
| penalty_count | output | CNT_W | Running total of squashed valid instructions |

## Verification
The assertions check several rules on every cycle. They check the fetch address stepping or jumping to the selected target, the same-cycle clearing of the squashed stages for each branch kind, and the absence of any masking when no redirect occurs. They also check that the counter moves only on a redirect, and then by exactly the number of live instructions in the masked stages. Other behaviour can only be shown by the bench's directed scenarios: which target wins when both branch kinds fire together, the exact bubble pattern seen after each kind of redirect, the cycle on which a target retires, and the penalty of a branch that follows an earlier squash with gaps behind it.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  localparam int NSTG  = 6;
  localparam int ST_FI = 0;
  localparam int ST_DI = 1;
  localparam int ST_CO = 2;
  localparam int ST_FO = 3;
  localparam int ST_EI = 4;
  localparam int ST_WO = 5;

  localparam int CNT_BITS = $clog2(NSTG + 1);

  localparam logic [1:0] KIND_PLAIN = 2'b00;
  localparam logic [1:0] KIND_JUMP  = 2'b01;
  localparam logic [1:0] KIND_COND  = 2'b10;

  // Stages younger than the redirecting stage; an older redirect wins.
  function automatic logic [NSTG-1:0] kill_mask(input logic cond_hit, input logic jump_hit);
    logic [NSTG-1:0] m;
    m = '0;
    if (cond_hit)
      m = NSTG'((1 << ST_EI) - 1);
    else if (jump_hit)
      m = NSTG'((1 << ST_CO) - 1);
    return m;
  endfunction

  function automatic logic [CNT_BITS-1:0] live_count(input logic [NSTG-1:0] v);
    logic [CNT_BITS-1:0] n;
    n = '0;
    for (int i = 0; i < NSTG; i++)
      n = n + CNT_BITS'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/pfc_stage_reg.sv
module pfc_stage_reg #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            d_valid,
  input  logic [1:0]      d_kind,
  input  logic [PC_W-1:0] d_pc,
  input  logic [PC_W-1:0] d_tgt,
  output logic            q_valid,
  output logic [1:0]      q_kind,
  output logic [PC_W-1:0] q_pc,
  output logic [PC_W-1:0] q_tgt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_kind  <= 2'b00;
      q_pc    <= '0;
      q_tgt   <= '0;
    end else begin
      q_valid <= d_valid;
      q_kind  <= d_kind;
      q_pc    <= d_pc;
      q_tgt   <= d_tgt;
    end
  end

endmodule

// File: rtl/pfc_redirect.sv
module pfc_redirect
  import pfc_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            co_valid,
  input  logic [1:0]      co_kind,
  input  logic [PC_W-1:0] co_tgt,
  input  logic            ei_valid,
  input  logic [1:0]      ei_kind,
  input  logic [PC_W-1:0] ei_tgt,
  input  logic            exec_taken,
  output logic            jump_hit,
  output logic            cond_hit,
  output logic            redir,
  output logic [PC_W-1:0] redir_tgt
);

  always_comb begin
    jump_hit  = co_valid && (co_kind == KIND_JUMP);
    cond_hit  = ei_valid && (ei_kind == KIND_COND) && exec_taken;
    redir     = jump_hit || cond_hit;
    redir_tgt = cond_hit ? ei_tgt : co_tgt;
  end

endmodule

// File: rtl/pfc_penalty.sv
module pfc_penalty #(
  parameter int CNT_W = 16,
  parameter int ADD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADD_W-1:0] bump,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else
      count <= count + CNT_W'(bump);
  end

endmodule

// File: rtl/pfc_flush_ctrl.sv
module pfc_flush_ctrl
  import pfc_pkg::*;
#(
  parameter int              PC_W     = 16,
  parameter int              CNT_W    = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fetch_kind,
  input  logic [PC_W-1:0]     fetch_target,
  input  logic                exec_taken,
  output logic [PC_W-1:0]     fetch_pc,
  output logic [NSTG-1:0]     stage_valid,
  output logic [PC_W-1:0]     retire_pc,
  output logic [CNT_W-1:0]    penalty_count
);

  localparam int META_N = NSTG - 1;

  // stage registers
  logic [NSTG-1:0] raw_valid;
  logic [PC_W-1:0] pc_q  [NSTG];
  logic [1:0]      k_q   [META_N];
  logic [PC_W-1:0] tg_q  [META_N];

  // stage inputs
  logic [NSTG-1:0] d_v;
  logic [PC_W-1:0] d_pc  [NSTG];
  logic [1:0]      d_k   [META_N];
  logic [PC_W-1:0] d_tg  [META_N];

  // named internal events
  logic                jump_hit;
  logic                cond_hit;
  logic                redir;
  logic [PC_W-1:0]     redir_tgt;
  logic [NSTG-1:0]     kill;
  logic [CNT_BITS-1:0] squashed;

  pfc_redirect #(.PC_W(PC_W)) u_redir (
    .co_valid   (raw_valid[ST_CO]),
    .co_kind    (k_q[ST_CO]),
    .co_tgt     (tg_q[ST_CO]),
    .ei_valid   (raw_valid[ST_EI]),
    .ei_kind    (k_q[ST_EI]),
    .ei_tgt     (tg_q[ST_EI]),
    .exec_taken (exec_taken),
    .jump_hit   (jump_hit),
    .cond_hit   (cond_hit),
    .redir      (redir),
    .redir_tgt  (redir_tgt)
  );

  always_comb begin
    kill        = kill_mask(cond_hit, jump_hit);
    stage_valid = raw_valid & ~kill;
    squashed    = live_count(raw_valid & kill);
  end

  always_comb begin
    d_v[ST_FI]  = !redir;
    d_pc[ST_FI] = fetch_pc;
    d_k[ST_FI]  = fetch_kind;
    d_tg[ST_FI] = fetch_target;
    for (int i = 1; i < NSTG; i++) begin
      d_v[i]  = stage_valid[i-1];
      d_pc[i] = pc_q[i-1];
    end
    for (int i = 1; i < META_N; i++) begin
      d_k[i]  = k_q[i-1];
      d_tg[i] = tg_q[i-1];
    end
  end

  generate
    for (genvar g = 0; g < NSTG; g++) begin : g_stage
      if (g == ST_WO) begin : g_last
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            raw_valid[g] <= 1'b0;
            pc_q[g]      <= '0;
          end else begin
            raw_valid[g] <= d_v[g];
            pc_q[g]      <= d_pc[g];
          end
        end
      end else begin : g_mid
        pfc_stage_reg #(.PC_W(PC_W)) u_reg (
          .clk     (clk),
          .rst_n   (rst_n),
          .d_valid (d_v[g]),
          .d_kind  (d_k[g]),
          .d_pc    (d_pc[g]),
          .d_tgt   (d_tg[g]),
          .q_valid (raw_valid[g]),
          .q_kind  (k_q[g]),
          .q_pc    (pc_q[g]),
          .q_tgt   (tg_q[g])
        );
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fetch_pc <= RESET_PC;
    else if (redir)
      fetch_pc <= redir_tgt;
    else
      fetch_pc <= fetch_pc + PC_W'(1);
  end

  pfc_penalty #(.CNT_W(CNT_W), .ADD_W(CNT_BITS)) u_pen (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (squashed),
    .count (penalty_count)
  );

  assign retire_pc = pc_q[ST_WO];

endmodule

// File: rtl/pfc_flush_ctrl_chk.sv
module pfc_flush_ctrl_chk
  import pfc_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PC_W-1:0]  fetch_pc,
  input logic [NSTG-1:0]  stage_valid,
  input logic [NSTG-1:0]  raw_valid,
  input logic [CNT_W-1:0] penalty_count,
  input logic             redir,
  input logic [PC_W-1:0]  redir_tgt,
  input logic             jump_hit,
  input logic             cond_hit
);

  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !redir |=> fetch_pc == $past(fetch_pc) + PC_W'(1));

  assert_fetch_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redir |=> fetch_pc == $past(redir_tgt));

  assert_fetch_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redir |=> !raw_valid[ST_FI]);

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stage_valid[ST_EI] |=> stage_valid[ST_WO]);

  assert_jump_squash_R4: assert property (@(posedge clk) disable iff (!rst_n)
    jump_hit |-> stage_valid[ST_DI:ST_FI] == '0);

  assert_cond_squash_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cond_hit |-> stage_valid[ST_FO:ST_FI] == '0);

  assert_no_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !redir |-> stage_valid == raw_valid);

  assert_older_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redir |-> stage_valid[ST_WO:ST_EI] == raw_valid[ST_WO:ST_EI]);

  assert_penalty_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !redir |=> $stable(penalty_count));

  assert_penalty_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_hit && !cond_hit) |=>
      penalty_count == $past(penalty_count) + CNT_W'($countones($past(raw_valid[ST_DI:ST_FI]))));

  assert_penalty_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cond_hit |=>
      penalty_count == $past(penalty_count) + CNT_W'($countones($past(raw_valid[ST_FO:ST_FI]))));

endmodule

bind pfc_flush_ctrl pfc_flush_ctrl_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetch_pc      (fetch_pc),
  .stage_valid   (stage_valid),
  .raw_valid     (raw_valid),
  .penalty_count (penalty_count),
  .redir         (redir),
  .redir_tgt     (redir_tgt),
  .jump_hit      (jump_hit),
  .cond_hit      (cond_hit)
);

// File: tb/pfc_flush_ctrl_tb.sv
`timescale 1ns/1ps
module pfc_flush_ctrl_tb;

  localparam int PC_W  = 16;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       fetch_kind;
  logic [PC_W-1:0]  fetch_target;
  logic             exec_taken = 1'b0;
  logic [PC_W-1:0]  fetch_pc;
  logic [5:0]       stage_valid;
  logic [PC_W-1:0]  retire_pc;
  logic [CNT_W-1:0] penalty_count;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  int scen   = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pfc_flush_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W), .RESET_PC('0)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_kind    (fetch_kind),
    .fetch_target  (fetch_target),
    .exec_taken    (exec_taken),
    .fetch_pc      (fetch_pc),
    .stage_valid   (stage_valid),
    .retire_pc     (retire_pc),
    .penalty_count (penalty_count)
  );

  // Program image per scenario: 01 jump, 10 conditional, 00 plain
  always_comb begin
    fetch_kind   = 2'b00;
    fetch_target = '0;
    case (scen)
      1: if (fetch_pc == 3) begin fetch_kind = 2'b01; fetch_target = 20; end
      2: if (fetch_pc == 2) begin fetch_kind = 2'b10; fetch_target = 40; end
      3: begin
        if (fetch_pc == 1) begin fetch_kind = 2'b10; fetch_target = 50; end
        if (fetch_pc == 3) begin fetch_kind = 2'b01; fetch_target = 60; end
      end
      4: begin
        if (fetch_pc == 1) begin fetch_kind = 2'b10; fetch_target = 50; end
        if (fetch_pc == 2) begin fetch_kind = 2'b01; fetch_target = 70; end
      end
      default: ;
    endcase
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input int s, input logic taken);
    @(negedge clk);
    rst_n = 1'b0;
    scen = s;
    exec_taken = taken;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    edges = 0;
  endtask

  // wait until k clock edges have passed since reset release, sample at negedge
  task automatic goto(input int k);
    repeat (k - edges) @(negedge clk);
    edges = k;
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 valid in reset", 32'(stage_valid), 0);
    chk("R1 fetch_pc in reset", 32'(fetch_pc), 0);
    chk("R1 penalty in reset", 32'(penalty_count), 0);
  endtask

  task automatic t_fill;
    start(0, 1'b1); // taken flag high with no conditional present
    goto(1);
    chk("R2 first entry", 32'(stage_valid), 32'(6'b000001));
    chk("R2 fetch step", 32'(fetch_pc), 1);
    goto(6);
    chk("R3 full pipe", 32'(stage_valid), 32'(6'b111111));
    chk("R3 first retire", 32'(retire_pc), 0);
    goto(8);
    chk("R3 retire order", 32'(retire_pc), 2);
    chk("R2 fetch count", 32'(fetch_pc), 8);
    chk("R6 taken ignored", 32'(penalty_count), 0);
    chk("R6 no bubbles", 32'(stage_valid), 32'(6'b111111));
  endtask

  task automatic t_jump;
    start(1, 1'b0);
    goto(6);
    chk("R4 same-cycle squash", 32'(stage_valid), 32'(6'b111100));
    chk("R4 fetch before redirect", 32'(fetch_pc), 6);
    chk("R8 no count before edge", 32'(penalty_count), 0);
    goto(7);
    chk("R4 fetch target", 32'(fetch_pc), 20);
    chk("R8 jump penalty", 32'(penalty_count), 2);
    chk("R7 fetch dropped", 32'(stage_valid), 32'(6'b111000));
    goto(8);
    chk("R7 target enters", 32'(stage_valid), 32'(6'b110001));
    chk("R2 after target", 32'(fetch_pc), 21);
    goto(9);
    chk("R10 jump retires", 32'(retire_pc), 3);
    goto(13);
    chk("R3 target retires", 32'(retire_pc), 20);
    chk("R3 target valid", 32'(stage_valid[5]), 1);
  endtask

  task automatic t_cond_taken;
    start(2, 1'b1);
    goto(7);
    chk("R5 same-cycle squash", 32'(stage_valid), 32'(6'b110000));
    chk("R5 fetch before redirect", 32'(fetch_pc), 7);
    goto(8);
    chk("R5 fetch target", 32'(fetch_pc), 40);
    chk("R8 cond penalty", 32'(penalty_count), 4);
    chk("R10 branch retires", 32'(retire_pc), 2);
    chk("R7 empty behind", 32'(stage_valid), 32'(6'b100000));
    goto(9);
    chk("R7 target enters", 32'(stage_valid), 32'(6'b000001));
    goto(14);
    chk("R3 target retires", 32'(retire_pc), 40);
  endtask

  task automatic t_cond_not_taken;
    start(2, 1'b0);
    goto(7);
    chk("R6 no squash", 32'(stage_valid), 32'(6'b111111));
    goto(8);
    chk("R6 fetch in order", 32'(fetch_pc), 8);
    chk("R6 no penalty", 32'(penalty_count), 0);
    chk("R6 retire in order", 32'(retire_pc), 2);
  endtask

  task automatic t_priority;
    start(3, 1'b1);
    goto(6);
    chk("R9 combined squash", 32'(stage_valid), 32'(6'b110000));
    goto(7);
    chk("R9 older target wins", 32'(fetch_pc), 50);
    chk("R9 older penalty", 32'(penalty_count), 4);
  endtask

  task automatic t_stacked;
    start(4, 1'b1);
    goto(5);
    chk("R4 jump squash", 32'(stage_valid), 32'(6'b011100));
    goto(6);
    chk("R8 first penalty", 32'(penalty_count), 2);
    chk("R4 jump target", 32'(fetch_pc), 70);
    chk("R5 squash with gaps", 32'(stage_valid), 32'(6'b110000));
    goto(7);
    chk("R8 only live counted", 32'(penalty_count), 3);
    chk("R5 cond target", 32'(fetch_pc), 50);
    chk("R10 cond retires", 32'(retire_pc), 1);
  endtask

  initial begin
    t_reset_state();
    t_fill();
    t_jump();
    t_cond_taken();
    t_cond_not_taken();
    t_priority();
    t_stacked();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule